// File: doc/BRIEF.md
# Glitch-Free Delay-Line Phase Stepper

This block moves the output clock of a delay-locked loop to a new sampling phase. It does this through a fixed series of read-modify-write updates to the loop's 32-bit configuration register. The register lives outside the block. The block reads it on `cfg_rd` and writes it with a one-cycle `cfg_we` strobe on `cfg_wdata`. A readback of the clock-output enable, `ck_out_ack`, comes back from the loop after some latency, and the block waits on it at two points.

A start strobe with a 4-bit phase index begins the sequence:
1. Tracking passes to the external recovery path.
2. The output clock is gated off, and the block waits for the readback to confirm it.
3. The phase field is loaded with the Gray-coded phase.
4. The output clock is re-enabled, and the block waits for its confirmation.
5. Tracking returns to the internal recovery path.

Each wait polls once per microsecond tick, for a bounded number of polls. If a wait runs out of polls, the block abandons the register where it stands and raises a sticky timeout flag.

Top module: `dll_phase_seq`

## Requirements
- R1: After reset, `busy`, `done`, `timeout_err` and `cfg_we` are all 0.
- R2: The first write after an accepted start changes only these bits: it clears bit 17 (internal recovery enable) and bit 18 (clock-output enable), and sets bit 19 (external recovery enable) and bit 16 (loop enable).
- R3: The phase write follows only after `ck_out_ack` has been seen at 0. It changes only bits 23:20, and it never changes them while bit 18 is set.
- R4: Phase index i (0..15) puts this value in bits 23:20, listed for i = 0 upward: 0,1,3,2,6,7,5,4,12,13,15,14,10,11,9,8.
- R5: The next write sets bit 18. The final write follows only after `ck_out_ack` has been seen at 1.
- R6: The final write sets bit 17 and clears bit 19. A successful sequence makes exactly four writes and ends with a one-cycle `done` pulse.
- R7: Each wait samples `ck_out_ack` once on entry and then once every `TICK_CYCLES` cycles, for at most `POLL_LIMIT` samples. A readback that becomes valid L cycles after the enable write is accepted when ceil(L/`TICK_CYCLES`) < `POLL_LIMIT`. Otherwise `timeout_err` rises on the cycle of the last sample.
- R8: `busy` is high from the accepted start until `done` or `timeout_err`. No write happens while `busy` is low, and a start seen while `busy` is high has no effect.
- R9: Every write copies bits 31:24 and 15:0 unchanged from `cfg_rd`.
- R10: After a timeout, no further write occurs and `timeout_err` stays high until the next start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a phase change (accepted only when idle) |
| phase_idx | input | 4 | Target phase index 0..15 |
| cfg_rd | input | 32 | Current value of the loop configuration register |
| ck_out_ack | input | 1 | Clock-output enable readback from the loop |
| cfg_we | output | 1 | Write strobe for the configuration register |
| cfg_wdata | output | 32 | Value to write |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| timeout_err | output | 1 | Sticky wait-timeout flag |

## Verification
The bench builds the block with `TICK_CYCLES` = 4 and keeps the default `POLL_LIMIT` of 50. A full poll window then lasts 196 cycles. Because the window is short, the bench can place the loop latency exactly at the last accepted sample (196) and at one cycle past it (197). It can also drive both waits into timeout with a stuck readback. Every case checks the exact cycle of `done` or `timeout_err` against the tick spacing.

// File: rtl/dll_phase_seq.sv
module dll_phase_seq #(
  parameter int TICK_CYCLES = 100,
  parameter int POLL_LIMIT  = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [3:0]  phase_idx,
  input  logic [31:0] cfg_rd,
  input  logic        ck_out_ack,
  output logic        cfg_we,
  output logic [31:0] cfg_wdata,
  output logic        busy,
  output logic        done,
  output logic        timeout_err
);

  localparam int TW = $clog2(TICK_CYCLES + 1);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam int B_LOOP = 16;
  localparam int B_INT  = 17;
  localparam int B_CKO  = 18;
  localparam int B_EXT  = 19;
  localparam int F_LO   = 20;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HANDOFF, ST_GATE_WAIT, ST_PHASE, ST_UNGATE, ST_OPEN_WAIT, ST_RETURN
  } st_t;

  st_t           st;
  logic [3:0]    phase_q;
  logic [TW-1:0] tick_cnt;
  logic [PW-1:0] poll_cnt;
  logic          done_q, err_q;

  wire [3:0] gray     = phase_q ^ (phase_q >> 1);
  wire       waiting  = (st == ST_GATE_WAIT) || (st == ST_OPEN_WAIT);
  wire       want     = (st == ST_OPEN_WAIT);
  wire       poll_now = waiting && (tick_cnt == '0);
  wire       hit      = poll_now && (ck_out_ack == want);
  wire       give_up  = poll_now && !hit && (poll_cnt == PW'(POLL_LIMIT - 1));

  assign busy        = (st != ST_IDLE);
  assign done        = done_q;
  assign timeout_err = err_q;

  always_comb begin
    cfg_we    = 1'b1;
    cfg_wdata = cfg_rd;
    case (st)
      ST_HANDOFF: begin
        cfg_wdata[B_INT]  = 1'b0;
        cfg_wdata[B_CKO]  = 1'b0;
        cfg_wdata[B_EXT]  = 1'b1;
        cfg_wdata[B_LOOP] = 1'b1;
      end
      ST_PHASE:  cfg_wdata[F_LO+3:F_LO] = gray;
      ST_UNGATE: cfg_wdata[B_CKO] = 1'b1;
      ST_RETURN: begin
        cfg_wdata[B_INT] = 1'b1;
        cfg_wdata[B_EXT] = 1'b0;
      end
      default: cfg_we = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      phase_q  <= '0;
      tick_cnt <= '0;
      poll_cnt <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          phase_q <= phase_idx;
          err_q   <= 1'b0;
          st      <= ST_HANDOFF;
        end
        ST_HANDOFF, ST_UNGATE: begin
          tick_cnt <= '0;
          poll_cnt <= '0;
          st       <= (st == ST_HANDOFF) ? ST_GATE_WAIT : ST_OPEN_WAIT;
        end
        ST_GATE_WAIT, ST_OPEN_WAIT: begin
          if (hit) begin
            st <= (st == ST_GATE_WAIT) ? ST_PHASE : ST_RETURN;
          end else if (give_up) begin
            err_q <= 1'b1;
            st    <= ST_IDLE;
          end else if (poll_now) begin
            poll_cnt <= poll_cnt + 1'b1;
            tick_cnt <= TW'(TICK_CYCLES - 1);
          end else begin
            tick_cnt <= tick_cnt - 1'b1;
          end
        end
        ST_PHASE:  st <= ST_UNGATE;
        ST_RETURN: begin
          done_q <= 1'b1;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dll_phase_seq_chk.sv
module dll_phase_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [31:0] cfg_rd,
  input logic        cfg_we,
  input logic [31:0] cfg_wdata,
  input logic        busy,
  input logic        done,
  input logic        timeout_err
);

  AST_WRITE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) cfg_we |-> busy); // R8
  AST_KEEP_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> (cfg_wdata[15:0] == cfg_rd[15:0] && cfg_wdata[31:24] == cfg_rd[31:24])); // R9
  AST_PHASE_ONLY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[23:20] != cfg_rd[23:20]) |-> (!cfg_rd[18] && !cfg_wdata[18])); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
  AST_DONE_NOT_ERR: assert property (@(posedge clk) disable iff (!rst_n) !(done && timeout_err)); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_err && !start) |=> timeout_err); // R10
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n) $rose(timeout_err) |-> !busy); // R8

endmodule

bind dll_phase_seq dll_phase_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cfg_rd(cfg_rd), .cfg_we(cfg_we),
  .cfg_wdata(cfg_wdata), .busy(busy), .done(done), .timeout_err(timeout_err)
);

// File: tb/test_dll_phase_seq.sv
module test_dll_phase_seq;
  localparam int T = 4;
  localparam int PL = 50;
  localparam logic [3:0] GRAY [16] = '{4'd0, 4'd1, 4'd3, 4'd2, 4'd6, 4'd7, 4'd5, 4'd4,
                                       4'd12, 4'd13, 4'd15, 4'd14, 4'd10, 4'd11, 4'd9, 4'd8};
  // {init[43:12], phase[11:8], latency[7:0]}
  localparam logic [43:0] VEC [6] = '{
    {32'h0000_0000, 4'd0,  8'd1},
    {32'h8765_4321, 4'd6,  8'd2},
    {32'hFFFF_FFFF, 4'd15, 8'd3},
    {32'h0005_A5A5, 4'd7,  8'd8},
    {32'h1234_0000, 4'd10, 8'd4},
    {32'hC03C_00F0, 4'd5,  8'd196}
  };

  logic clk = 0, rst_n = 0, start = 0, ack, cfg_we, busy, done, terr;
  logic [3:0] phase = 0;
  logic [31:0] creg, cfg_wdata, cfg_init = 0;
  int lat = 1, cnt = 0, wcnt = 0, tests = 0, fails = 0;
  bit stuck = 0;
  logic [31:0] wlog [8];
  logic wack [8];

  always #5 clk = ~clk;

  dll_phase_seq #(.TICK_CYCLES(T), .POLL_LIMIT(PL)) i_dll_phase_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .phase_idx(phase), .cfg_rd(creg),
    .ck_out_ack(ack), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .busy(busy),
    .done(done), .timeout_err(terr));

  always @(posedge clk) begin
    if (!rst_n) creg <= cfg_init;
    else if (cfg_we) begin
      creg <= cfg_wdata;
      if (wcnt < 8) begin wlog[wcnt] <= cfg_wdata; wack[wcnt] <= ack; end
      wcnt <= wcnt + 1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin ack <= cfg_init[18]; cnt <= 0; end
    else if (!stuck && ack != creg[18]) begin
      if (cnt == lat - 1) begin ack <= creg[18]; cnt <= 0; end
      else cnt <= cnt + 1;
    end else cnt <= 0;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [31:0] init);
    @(negedge clk); rst_n = 0; cfg_init = init;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic run(input logic [3:0] ph, output int n);
    wcnt = 0;
    @(negedge clk); start = 1; phase = ph;
    @(negedge clk); start = 0; n = 0;
    while (!(done || terr) && n < 2000) begin @(negedge clk); n++; end
  endtask

  function automatic int ceil_t(input int l);
    return (l + T - 1) / T;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    logic [31:0] snap, exp;
    do_reset(32'h0);
    check(!busy && !done && !terr && !cfg_we, "R1", "reset outputs",
          {busy, done, terr, cfg_we}, 0);

    foreach (VEC[v]) begin
      logic [31:0] init = VEC[v][43:12];
      logic [3:0]  ph   = VEC[v][11:8];
      int          l    = int'(VEC[v][7:0]);
      int          en;
      lat = l; stuck = 0;
      do_reset(init);
      run(ph, n);
      exp = init;
      exp[23:20] = GRAY[ph];
      exp[19] = 0; exp[18] = 1; exp[17] = 1; exp[16] = 1;
      en = 6 + T * ((init[18] ? ceil_t(l) : 0) + ceil_t(l));
      check(done && !terr, "R6", "done without error", {done, terr}, 2);
      check(n == en, "R7", "done cycle", n, en);
      check(wcnt == 4, "R6", "write count", wcnt, 4);
      check(wlog[0][19:16] == 4'b1001 && (wlog[0] ^ init) == (32'h000F_0000 & (wlog[0] ^ init)),
            "R2", "handoff write", wlog[0], {init[31:20], 4'b1001, init[15:0]});
      check(wack[1] == 0 && (wlog[1] ^ wlog[0]) == ((wlog[1] ^ wlog[0]) & 32'h00F0_0000),
            "R3", "phase write gated", wlog[1], {wlog[0][31:24], GRAY[ph], wlog[0][19:0]});
      check(wlog[1][23:20] == GRAY[ph], "R4", "gray field", wlog[1][23:20], GRAY[ph]);
      check(wlog[2][18] && wack[3] == 1, "R5", "ungate then confirmed", wlog[2], wlog[1] | 32'h4_0000);
      check(creg == exp, "R9", "final register", creg, exp);
      @(negedge clk);
      check(!done && !busy, "R8", "done one cycle, idle", {done, busy}, 0);
    end

    lat = 4; stuck = 0;
    do_reset(32'h0000_0000);
    wcnt = 0;
    @(negedge clk); start = 1; phase = 4'd3;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    check(busy, "R8", "busy mid sequence", busy, 1);
    start = 1; phase = 4'd9;
    @(negedge clk); start = 0;
    while (!done && !terr) @(negedge clk);
    check(creg[23:20] == GRAY[3] && wcnt == 4, "R8", "start while busy ignored",
          {creg[23:20], 4'(wcnt)}, {GRAY[3], 4'd4});

    lat = 2; stuck = 1;
    do_reset(32'h0004_0000);
    run(4'd2, n);
    check(terr && !done, "R7", "gate wait timeout", {terr, done}, 2);
    check(n == 2 + (PL - 1) * T, "R7", "gate timeout cycle", n, 2 + (PL - 1) * T);
    snap = creg;
    check(snap == wlog[0] && wcnt == 1, "R10", "register left at abort", snap, wlog[0]);
    repeat (10) @(negedge clk);
    check(terr && creg == snap && wcnt == 1 && !busy, "R10", "error sticky, no writes",
          {31'(0), terr}, 1);
    stuck = 0;
    @(negedge clk); start = 1; phase = 4'd1;
    @(negedge clk); start = 0;
    check(!terr && busy, "R10", "next start clears error", {terr, busy}, 1);
    while (!done && !terr) @(negedge clk);
    check(done && creg[23:20] == GRAY[1], "R4", "recovery run", creg[23:20], GRAY[1]);

    lat = 2; stuck = 1;
    do_reset(32'h0000_0000);
    run(4'd12, n);
    check(terr && n == 5 + (PL - 1) * T, "R7", "open wait timeout cycle", n, 5 + (PL - 1) * T);
    check(creg[19:16] == 4'b1101 && creg[23:20] == GRAY[12] && wcnt == 3, "R10",
          "register at open abort", creg, {8'h0, GRAY[12], 4'b1101, 16'h0});

    lat = (PL - 1) * T + 1; stuck = 0;
    do_reset(32'h0004_0000);
    run(4'd8, n);
    check(terr && n == 2 + (PL - 1) * T, "R7", "latency one past window", n, 2 + (PL - 1) * T);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule